// File: doc/BRIEF.md
# Phase-Synchronised PWM Pair with One-Shot Global Load

This block drives two edge-aligned PWM waveforms from one clock. A master channel runs a free up-counter. A slave channel runs a second up-counter. Every time the master counter passes through zero, the slave counter is re-seeded with a programmable phase value. The two waveforms therefore keep a fixed phase relation, set by that value.

Period, compare and phase settings are written through a simple write-enable/address/data port into shadow registers. Shadow writes have no effect on the waveforms until software arms a one-shot global load. At the first master zero after arming, every shadow value of both channels becomes active on the same clock edge. The arm flag then clears by itself, and a one-cycle pulse confirms the transfer.

A change of phase can make the slave counter leap over its compare value. When that happens, the slave output misses its clear point and stays high much longer than intended. An optional guard input bounds this by driving the slave output low on such a leap.

Top module: `pwm_phase_pair`

## Requirements
- R1: The master counter counts up by one per clock from 0 to the active master period P and returns to 0 on the following clock, so the master waveform repeats every P+1 cycles.
- R2: Each output goes high on the clock after its counter reads 0 and goes low on the clock after its counter equals that channel's active compare value C, giving a high time of C cycles; if both conditions hold at once, low wins.
- R3: In the clock after each master zero, the slave counter holds the active slave phase. Otherwise it counts up to the active slave period and wraps to 0. With defaults (period 600, phase 200, compare 300) the slave rises 402 cycles after the master.
- R4: Shadow writes change no waveform until a global transfer. The address map is: 0 master period, 1 master compare, 2 slave period, 3 slave phase, 4 slave compare. Writes to addresses 5 to 7 are ignored.
- R5: After a one-cycle pulse on `arm_load`, the first master zero copies all five shadow registers into the active set on one edge. A newly loaded phase is applied to the slave counter on that same edge. Shadow writes made while armed are the ones transferred.
- R6: A transfer clears the arm flag, so later master zeros transfer nothing until the next arm. `load_done` is high for exactly one cycle per transfer, in the cycle where the master output rises.
- R7: If the phase applied at a master zero lands above the slave compare value while the slave counter is still below it, and the guard is off, the slave output stays high through the skipped compare. In the 600/200/300 to 1200/400/300 change, this gives one high pulse of 1301 cycles.
- R8: With `guard_en` high, such a leap drives the slave output low on the same edge that loads the phase. Phase loads that do not leap leave the output unchanged.
- R9: After reset both counters are 0, both outputs and `load_done` are low, nothing is armed, and active and shadow registers hold the parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | 3 | Shadow register address |
| wr_data | input | CW | Shadow register write data |
| arm_load | input | 1 | One-cycle pulse that arms the one-shot global load |
| guard_en | input | 1 | Enables forcing the slave output low on a phase leap past compare |
| pwm_master | output | 1 | Master PWM waveform |
| pwm_slave | output | 1 | Slave PWM waveform |
| load_done | output | 1 | One-cycle pulse for each global transfer |

## Verification
The embedded assertions check on every cycle that:
- the master counter stays within its period;
- the slave counter holds the active phase right after every master zero;
- active settings change only on a transfer;
- the arm flag clears on a transfer unless re-armed in that same cycle;
- the master output is low after a compare match.

Other behaviour can only be shown by the bench's directed scenarios, because it is a matter of end-to-end cycle distances:
- waveform period and high time;
- the 402-cycle slave lag;
- a shadow write leaving the waveforms untouched;
- a transfer happening once and only once per arm;
- the 1301-cycle stretched pulse in the frequency-doubling change, and its truncation to 199 cycles when the guard is on.

// File: rtl/pwm_phase_pair.sv
module pwm_phase_pair #(
  parameter int CW = 16,
  parameter logic [CW-1:0] RST_PRD = 16'd600,
  parameter logic [CW-1:0] RST_PHS = 16'd200,
  parameter logic [CW-1:0] RST_CMP = 16'd300
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          arm_load,
  input  logic          guard_en,
  output logic          pwm_master,
  output logic          pwm_slave,
  output logic          load_done
);

  localparam logic [2:0] A_MPRD = 3'd0;
  localparam logic [2:0] A_MCMP = 3'd1;
  localparam logic [2:0] A_SPRD = 3'd2;
  localparam logic [2:0] A_SPHS = 3'd3;
  localparam logic [2:0] A_SCMP = 3'd4;

  logic [CW-1:0] sh_mprd, sh_mcmp, sh_sprd, sh_sphs, sh_scmp;
  logic [CW-1:0] ac_mprd, ac_mcmp, ac_sprd, ac_sphs, ac_scmp;
  logic [CW-1:0] m_ctr, s_ctr;
  logic          armed;
  logic          m_zero, xfer, leap;
  logic [CW-1:0] phs_eff, scmp_eff;

  assign m_zero   = (m_ctr == '0);
  assign xfer     = armed && m_zero;
  assign phs_eff  = xfer ? sh_sphs : ac_sphs;
  assign scmp_eff = xfer ? sh_scmp : ac_scmp;
  assign leap     = m_zero && (s_ctr < scmp_eff) && (phs_eff > scmp_eff);

  // shadow set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_mprd <= RST_PRD;
      sh_mcmp <= RST_CMP;
      sh_sprd <= RST_PRD;
      sh_sphs <= RST_PHS;
      sh_scmp <= RST_CMP;
    end else if (wr_en) begin
      case (wr_addr)
        A_MPRD:  sh_mprd <= wr_data;
        A_MCMP:  sh_mcmp <= wr_data;
        A_SPRD:  sh_sprd <= wr_data;
        A_SPHS:  sh_sphs <= wr_data;
        A_SCMP:  sh_scmp <= wr_data;
        default: ;
      endcase
    end
  end

  // active set, one-shot arm and transfer pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_mprd   <= RST_PRD;
      ac_mcmp   <= RST_CMP;
      ac_sprd   <= RST_PRD;
      ac_sphs   <= RST_PHS;
      ac_scmp   <= RST_CMP;
      armed     <= 1'b0;
      load_done <= 1'b0;
    end else begin
      if (xfer) begin
        ac_mprd <= sh_mprd;
        ac_mcmp <= sh_mcmp;
        ac_sprd <= sh_sprd;
        ac_sphs <= sh_sphs;
        ac_scmp <= sh_scmp;
      end
      armed     <= (armed && !xfer) || arm_load;
      load_done <= xfer;
    end
  end

  // counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctr <= '0;
      s_ctr <= '0;
    end else begin
      m_ctr <= (m_ctr >= ac_mprd) ? '0 : m_ctr + 1'b1;
      if (m_zero)                s_ctr <= phs_eff;
      else if (s_ctr >= ac_sprd) s_ctr <= '0;
      else                       s_ctr <= s_ctr + 1'b1;
    end
  end

  // outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_master <= 1'b0;
      pwm_slave  <= 1'b0;
    end else begin
      if (m_ctr == ac_mcmp)  pwm_master <= 1'b0;
      else if (m_zero)       pwm_master <= 1'b1;
      if (guard_en && leap)  pwm_slave <= 1'b0;
      else if (s_ctr == ac_scmp) pwm_slave <= 1'b0;
      else if (s_ctr == '0)  pwm_slave <= 1'b1;
    end
  end

  AST_MCTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    m_ctr <= ac_mprd); // R1

  AST_MCMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ctr == ac_mcmp) |=> !pwm_master); // R2

  AST_SLAVE_PHASE_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    m_zero |=> (s_ctr == ac_sphs)); // R3

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> ($stable(ac_mprd) && $stable(ac_mcmp) && $stable(ac_sprd)
                    && $stable(ac_sphs) && $stable(ac_scmp))); // R4

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (armed == $past(arm_load))); // R6

  AST_DONE_WITH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (pwm_master || ac_mcmp == '0)); // R6

endmodule

// File: tb/test_pwm_phase_pair.sv
module test_pwm_phase_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        arm_load = 1'b0;
  logic        guard_en = 1'b0;
  logic        pwm_master, pwm_slave, load_done;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int done_cnt = 0;

  pwm_phase_pair i_pwm_phase_pair (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .arm_load(arm_load), .guard_en(guard_en),
    .pwm_master(pwm_master), .pwm_slave(pwm_slave), .load_done(load_done)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && load_done) done_cnt <= done_cnt + 1;
    if (cyc > 200000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 200000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk);
    arm_load = 1'b1;
    @(negedge clk);
    arm_load = 1'b0;
  endtask

  // waits for an edge on a chosen output and returns the cycle count
  task automatic wait_edge(input bit slave, input bit rising, output int t);
    bit prev, cur;
    prev = slave ? pwm_slave : pwm_master;
    forever begin
      @(negedge clk);
      cur = slave ? pwm_slave : pwm_master;
      if (cur == rising && prev != rising) break;
      prev = cur;
    end
    t = cyc;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 master out in reset", int'(pwm_master), 0);
    check("R9 slave out in reset", int'(pwm_slave), 0);
    check("R9 load_done in reset", int'(load_done), 0);
  endtask

  task automatic t_steady();
    int t0, tf, ts, t1, tsf;
    do_reset();
    wait_edge(0, 1, t0);
    wait_edge(0, 1, t0);
    wait_edge(0, 0, tf);
    wait_edge(1, 1, ts);
    wait_edge(0, 1, t1);
    wait_edge(1, 0, tsf);
    check("R1 master period", t1 - t0, 601);
    check("R2 master high time", tf - t0, 300);
    check("R3 slave lag", ts - t0, 402);
    check("R2 slave high time", tsf - ts, 300);
  endtask

  task automatic t_no_arm();
    int t0, t1, t2, d0;
    do_reset();
    wait_edge(0, 1, t0);
    d0 = done_cnt;
    wr(3'd0, 16'd100);
    wr(3'd1, 16'd50);
    wait_edge(0, 1, t1);
    wait_edge(0, 1, t2);
    check("R4 period unchanged before arm", t1 - t0, 601);
    check("R4 period unchanged later", t2 - t1, 601);
    check("R4 no transfer without arm", done_cnt - d0, 0);
  endtask

  // arm first, then update shadows; returns key times
  task automatic freq_change(output int t0, output int ts, output int t1);
    wait_edge(0, 1, t0);
    wait_edge(0, 1, t0);
    arm();
    wr(3'd0, 16'd1200);
    wr(3'd2, 16'd1200);
    wr(3'd3, 16'd400);
    wr(3'd6, 16'd5);
    wait_edge(1, 1, ts);
    wait_edge(0, 1, t1);
  endtask

  task automatic t_oneshot_leap();
    int t0, ts, t1, tf, t2, ts2, tsf2, t3, d0;
    do_reset();
    guard_en = 1'b0;
    d0 = done_cnt;
    freq_change(t0, ts, t1);
    check("R6 load_done with master rise", int'(load_done), 1);
    check("R5 old period until transfer", t1 - t0, 601);
    wait_edge(1, 0, tf);
    check("R7 stretched slave pulse", tf - ts, 1301);
    wait_edge(0, 1, t2);
    check("R5 new master period", t2 - t1, 1201);
    wait_edge(1, 1, ts2);
    wait_edge(1, 0, tsf2);
    check("R5 new slave lag", ts2 - t2, 802);
    check("R4 addr 6 ignored, slave high", tsf2 - ts2, 300);
    wr(3'd0, 16'd900);
    wait_edge(0, 1, t3);
    wait_edge(0, 1, t3);
    check("R6 one transfer per arm", done_cnt - d0, 1);
    check("R6 no reload without arm", t3 - t2, 2 * 1201);
  endtask

  task automatic t_guard();
    int t0, ts, t1, tf, ts2, tsf2;
    do_reset();
    guard_en = 1'b1;
    freq_change(t0, ts, t1);
    check("R8 slave low at leap", int'(pwm_slave), 0);
    check("R8 truncated pulse", t1 - ts, 199);
    wait_edge(1, 1, ts2);
    wait_edge(1, 0, tsf2);
    check("R8 next slave rise", ts2 - t1, 802);
    check("R8 normal pulse after leap", tsf2 - ts2, 300);
    guard_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_steady();
    t_no_arm();
    t_oneshot_leap();
    t_guard();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule